// File: doc/BRIEF.md
# Single-Operand Shift/Rotate Unit

This unit computes the result and condition flags of one-operand read-modify-write instructions: negate, complement, logical and arithmetic right shift, rotate right and left through carry, left shift, decrement, increment, test, half swap and clear. It receives an operand of either byte or word width, a 4-bit operation code and the current carry flag. It returns the new value, new N, Z and C flags, a per-flag write mask, a write-back strobe and an invalid-code indication.

The surrounding pipeline fetches the operand and writes back the result. The unit only transforms the operand. Each accepted request produces its registered outputs one clock later. Between requests, the registered outputs keep their last values.

Top module: `sru_top`

## Requirements
- R1: `valid_o` is high exactly one cycle after `valid_i` was high at a rising edge. Result, flag, mask, write-back and invalid outputs load only on accepted requests and otherwise hold their values.
- R2: While `rst_ni` is low, every output is zero.
- R3: Code 0x4 shifts right and fills the MSB with 0. Code 0x7 shifts right and keeps the MSB. Both move the operand LSB into C.
- R4: Code 0x6 gives (result:C) = (carry_i:operand). Code 0x9 gives (C:result) = (operand:carry_i).
- R5: Code 0x8 shifts left, fills the LSB with 0 and moves the operand MSB into C.
- R6: Code 0xA decrements and code 0xC increments, modulo the width. The C mask bit is 0 and `c_o` equals `carry_i`.
- R7: Code 0x0 gives the two's-complement negation, with C = 1 when the operand is nonzero. Code 0x3 gives the one's complement, with C = 1.
- R8: Code 0xD returns the operand unchanged, with N and Z taken from it. `write_o` is 0 and the C mask bit is 0.
- R9: Code 0xE exchanges the two 4-bit halves of a byte operand, or the two bytes of a word operand. N and Z are written; C is not.
- R10: Code 0xF returns zero with N = 0 and Z = 1. C is not written.
- R11: N is the result MSB at the selected width, and Z is 1 exactly when the result is zero. In byte mode (`word_i` = 0), `operand_i[15:8]` has no effect and `result_o[15:8]` is zero.
- R12: Codes 0x1, 0x2, 0x5 and 0xB set `invalid_o`. For these codes the flag mask is 0, `write_o` is 0, the result is the width-masked operand and `c_o` equals `carry_i`.
- R13: `flag_we_o` bit 2 enables N, bit 1 enables Z and bit 0 enables C. Codes 0x0, 0x3, 0x4, 0x6, 0x7, 0x8 and 0x9 set all three bits. `write_o` is 1 for every valid code except 0xD.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| word_i | input | 1 | 1 selects word width, 0 selects byte width |
| op_i | input | 4 | Operation code |
| operand_i | input | 16 | Operand; byte mode uses bits 7:0 |
| carry_i | input | 1 | Current carry flag |
| valid_o | output | 1 | Result valid |
| result_o | output | 16 | Computed value |
| n_o | output | 1 | New negative flag |
| z_o | output | 1 | New zero flag |
| c_o | output | 1 | New carry flag (equals incoming carry when not written) |
| flag_we_o | output | 3 | Flag write mask {N, Z, C} |
| write_o | output | 1 | Result must be written back |
| invalid_o | output | 1 | Operation code not handled |

## Verification
A wrong width select or lane mix-up shows up in the first response to a byte request whose upper operand byte is nonzero: the upper result byte or the N flag comes out wrong. A stale carry path or a wrong mask shows up in the response one cycle after a rotate, increment or decrement. Because every output is registered once, any decode or datapath fault is visible one cycle after the request that exposes it. The idle-cycle hold checks expose a register that loads without a request.

// File: rtl/sru_pkg.sv
package sru_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NEG  = 4'h0,
    OP_RSV1 = 4'h1,
    OP_RSV2 = 4'h2,
    OP_CPL  = 4'h3,
    OP_SRL  = 4'h4,
    OP_RSV5 = 4'h5,
    OP_RRC  = 4'h6,
    OP_SRA  = 4'h7,
    OP_SLL  = 4'h8,
    OP_RLC  = 4'h9,
    OP_DEC  = 4'hA,
    OP_RSVB = 4'hB,
    OP_INC  = 4'hC,
    OP_TST  = 4'hD,
    OP_SWP  = 4'hE,
    OP_CLR  = 4'hF
  } sru_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
  } sru_flags_t;
endpackage

// File: rtl/sru_decode.sv
module sru_decode
  import sru_pkg::*;
(
  input  sru_op_e    op_i,
  output sru_flags_t we_o,
  output logic       wb_o,
  output logic       invalid_o
);
  always_comb begin
    we_o      = '{n: 1'b1, z: 1'b1, c: 1'b1};
    wb_o      = 1'b1;
    invalid_o = 1'b0;
    unique case (op_i)
      OP_NEG, OP_CPL, OP_SRL, OP_RRC, OP_SRA, OP_SLL, OP_RLC: ;
      OP_DEC, OP_INC, OP_SWP, OP_CLR: we_o.c = 1'b0;
      OP_TST: begin
        we_o.c = 1'b0;
        wb_o   = 1'b0;
      end
      default: begin
        we_o      = '0;
        wb_o      = 1'b0;
        invalid_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/sru_lane.sv
module sru_lane
  import sru_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] opnd_i,
  input  sru_op_e      op_i,
  input  logic         carry_i,
  output logic [W-1:0] res_o,
  output logic         c_o
);
  localparam int unsigned HALF = W / 2;

  always_comb begin
    res_o = opnd_i;
    c_o   = carry_i;
    unique case (op_i)
      OP_NEG: begin
        res_o = W'(0) - opnd_i;
        c_o   = |opnd_i;
      end
      OP_CPL: begin
        res_o = ~opnd_i;
        c_o   = 1'b1;
      end
      OP_SRL: begin
        res_o = {1'b0, opnd_i[W-1:1]};
        c_o   = opnd_i[0];
      end
      OP_SRA: begin
        res_o = {opnd_i[W-1], opnd_i[W-1:1]};
        c_o   = opnd_i[0];
      end
      OP_RRC: begin
        res_o = {carry_i, opnd_i[W-1:1]};
        c_o   = opnd_i[0];
      end
      OP_SLL: begin
        res_o = {opnd_i[W-2:0], 1'b0};
        c_o   = opnd_i[W-1];
      end
      OP_RLC: begin
        res_o = {opnd_i[W-2:0], carry_i};
        c_o   = opnd_i[W-1];
      end
      OP_DEC:  res_o = opnd_i - W'(1);
      OP_INC:  res_o = opnd_i + W'(1);
      OP_SWP:  res_o = {opnd_i[HALF-1:0], opnd_i[W-1:HALF]};
      OP_CLR:  res_o = '0;
      default: ;
    endcase
  end
endmodule

// File: rtl/sru_nz.sv
module sru_nz #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] res_i,
  output logic         n_o,
  output logic         z_o
);
  assign n_o = res_i[W-1];
  assign z_o = (res_i == '0);
endmodule

// File: rtl/sru_top.sv
module sru_top
  import sru_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              word_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic              carry_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              n_o,
  output logic              z_o,
  output logic              c_o,
  output logic [2:0]        flag_we_o,
  output logic              write_o,
  output logic              invalid_o
);
  localparam int unsigned BYTE_W  = DATA_W / 2;
  localparam int unsigned N_LANES = 2;

  sru_op_e    op;
  sru_flags_t we_d, we_q;
  logic       wb_d, inv_d;

  assign op = sru_op_e'(op_i);

  sru_decode u_dec (
    .op_i      (op),
    .we_o      (we_d),
    .wb_o      (wb_d),
    .invalid_o (inv_d)
  );

  logic [DATA_W-1:0] lane_res [N_LANES];
  logic              lane_c   [N_LANES];
  logic              lane_n   [N_LANES];
  logic              lane_z   [N_LANES];

  // lane 0 = byte width, lane 1 = word width
  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    localparam int unsigned LW = BYTE_W * (g + 1);
    logic [LW-1:0] r;
    sru_lane #(.W(LW)) u_lane (
      .opnd_i  (operand_i[LW-1:0]),
      .op_i    (op),
      .carry_i (carry_i),
      .res_o   (r),
      .c_o     (lane_c[g])
    );
    sru_nz #(.W(LW)) u_nz (
      .res_i (r),
      .n_o   (lane_n[g]),
      .z_o   (lane_z[g])
    );
    assign lane_res[g] = DATA_W'(r);
  end

  logic [DATA_W-1:0] res_q;
  sru_flags_t        fl_q;
  logic              valid_q, wb_q, inv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_q   <= '0;
      fl_q    <= '0;
      we_q    <= '0;
      wb_q    <= 1'b0;
      inv_q   <= 1'b0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        res_q   <= lane_res[word_i];
        fl_q.n  <= lane_n[word_i];
        fl_q.z  <= lane_z[word_i];
        fl_q.c  <= lane_c[word_i];
        we_q    <= we_d;
        wb_q    <= wb_d;
        inv_q   <= inv_d;
      end
    end
  end

  assign valid_o   = valid_q;
  assign result_o  = res_q;
  assign n_o       = fl_q.n;
  assign z_o       = fl_q.z;
  assign c_o       = fl_q.c;
  assign flag_we_o = we_q;
  assign write_o   = wb_q;
  assign invalid_o = inv_q;

  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i)); // R1
  AST_INC_DEC_KEEP_C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == OP_INC || op_i == OP_DEC))
    |=> (c_o == $past(carry_i) && !flag_we_o[0])); // R6
  AST_TEST_NO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_TST) |=> (!write_o && !flag_we_o[0])); // R8
  AST_CLR_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_CLR) |=> (result_o == '0 && z_o && !n_o)); // R10
  AST_Z_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && flag_we_o[1]) |-> (z_o == (result_o == '0))); // R11
  AST_INVALID_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> (flag_we_o == 3'b000 && !write_o)); // R12
endmodule

// File: tb/sru_top_tb_top.sv
module sru_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        word_i = 1'b0;
  logic [3:0]  op_i = 4'h0;
  logic [15:0] operand_i = 16'h0;
  logic        carry_i = 1'b0;
  logic        valid_o, n_o, z_o, c_o, write_o, invalid_o;
  logic [15:0] result_o;
  logic [2:0]  flag_we_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  sru_top dut_i (
    .clk_i, .rst_ni, .valid_i, .word_i, .op_i, .operand_i, .carry_i,
    .valid_o, .result_o, .n_o, .z_o, .c_o, .flag_we_o, .write_o, .invalid_o
  );

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'h4, 4'h7: return "R3";
      4'h6, 4'h9: return "R4";
      4'h8: return "R5";
      4'hA, 4'hC: return "R6";
      4'h0, 4'h3: return "R7";
      4'hD: return "R8";
      4'hE: return "R9";
      4'hF: return "R10";
      default: return "R12";
    endcase
  endfunction

  function automatic void ref_model(
    input logic w, input logic [3:0] op, input logic [15:0] a, input logic cin,
    output logic [15:0] r, output logic n, output logic z, output logic c,
    output logic [2:0] we, output logic wb, output logic inv);
    logic [15:0] m, x, top;
    logic msb;
    m   = w ? 16'hFFFF : 16'h00FF;
    top = w ? 16'h8000 : 16'h0080;
    x   = a & m;
    msb = (x & top) != 0;
    c = cin; we = 3'b111; wb = 1'b1; inv = 1'b0; r = x;
    case (op)
      4'h0: begin r = (16'h0 - x) & m; c = (x != 0); end
      4'h3: begin r = ~x & m; c = 1'b1; end
      4'h4: begin r = x >> 1; c = x[0]; end
      4'h7: begin r = (x >> 1) | (msb ? top : 16'h0); c = x[0]; end
      4'h6: begin r = (x >> 1) | (cin ? top : 16'h0); c = x[0]; end
      4'h8: begin r = (x << 1) & m; c = msb; end
      4'h9: begin r = ((x << 1) | {15'h0, cin}) & m; c = msb; end
      4'hA: begin r = (x - 16'h1) & m; we = 3'b110; end
      4'hC: begin r = (x + 16'h1) & m; we = 3'b110; end
      4'hD: begin we = 3'b110; wb = 1'b0; end
      4'hE: begin
        r = w ? {x[7:0], x[15:8]} : {8'h0, x[3:0], x[7:4]};
        we = 3'b110;
      end
      4'hF: begin r = 16'h0; we = 3'b110; end
      default: begin we = 3'b000; wb = 1'b0; inv = 1'b1; end
    endcase
    n = (r & top) != 0;
    z = (r == 16'h0);
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive at a falling edge, result is registered at the next rising edge,
  // sampled at the falling edge after it
  task automatic apply(input logic w, input logic [3:0] op, input logic [15:0] a,
                       input logic cin);
    logic [15:0] r;
    logic n, z, c, wb, inv;
    logic [2:0] we;
    string rq;
    ref_model(w, op, a, cin, r, n, z, c, we, wb, inv);
    rq = req_of(op);
    valid_i = 1'b1; word_i = w; op_i = op; operand_i = a; carry_i = cin;
    @(negedge clk_i);
    valid_i = 1'b0;
    if (valid_o !== 1'b1) check("R1", "valid_o", 32'(valid_o), 32'd1);
    if (!w && a[15:8] != 8'h0) rq = {rq, "/R11"};
    check(rq, "result", 32'(result_o), 32'(r));
    check(rq, "nzc", {29'h0, n_o, z_o, c_o}, {29'h0, n, z, c});
    check({rq, "/R13"}, "we/wb/inv", {27'h0, flag_we_o, write_o, invalid_o},
          {27'h0, we, wb, inv});
  endtask

  task automatic idle_hold();
    logic [15:0] r0;
    logic [2:0] f0;
    r0 = result_o;
    f0 = {n_o, z_o, c_o};
    valid_i = 1'b0; op_i = 4'($urandom); operand_i = 16'($urandom);
    carry_i = 1'($urandom); word_i = 1'($urandom);
    @(negedge clk_i);
    check("R1", "idle valid_o", 32'(valid_o), 32'd0);
    check("R1", "hold", {13'h0, result_o, n_o, z_o, c_o}, {13'h0, r0, f0});
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    if (!done) $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0021));
    repeat (3) @(negedge clk_i);
    check("R2", "reset outputs",
          {8'h0, valid_o, result_o, n_o, z_o, c_o, flag_we_o, write_o, invalid_o},
          32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // directed corners
    apply(1'b0, 4'h4, 16'h0081, 1'b0);
    apply(1'b0, 4'h7, 16'h0081, 1'b0);
    apply(1'b1, 4'h7, 16'h8000, 1'b1);
    apply(1'b0, 4'h6, 16'h0001, 1'b1);
    apply(1'b0, 4'h9, 16'h0080, 1'b0);
    apply(1'b1, 4'h9, 16'h7FFF, 1'b1);
    apply(1'b1, 4'h8, 16'h8001, 1'b0);
    apply(1'b0, 4'hC, 16'h00FF, 1'b1);
    apply(1'b0, 4'hA, 16'h0000, 1'b0);
    apply(1'b1, 4'hA, 16'h0000, 1'b1);
    apply(1'b0, 4'h0, 16'h0000, 1'b1);
    apply(1'b1, 4'h0, 16'h0001, 1'b0);
    apply(1'b0, 4'h3, 16'h00FF, 1'b0);
    apply(1'b0, 4'hD, 16'h0080, 1'b1);
    apply(1'b1, 4'hD, 16'h0000, 1'b0);
    apply(1'b0, 4'hE, 16'h001E, 1'b0);
    apply(1'b1, 4'hE, 16'h12AB, 1'b1);
    apply(1'b1, 4'hF, 16'hFFFF, 1'b1);
    apply(1'b0, 4'hC, 16'hFF00, 1'b0);
    apply(1'b0, 4'h8, 16'h5540, 1'b0);
    apply(1'b0, 4'h5, 16'hABCD, 1'b1);
    apply(1'b1, 4'hB, 16'hABCD, 1'b0);
    apply(1'b0, 4'h1, 16'h1234, 1'b1);
    apply(1'b1, 4'h2, 16'h8000, 1'b1);
    idle_hold();
    // random mix
    for (int i = 0; i < 3000; i++) begin
      apply(1'($urandom), 4'($urandom), 16'($urandom), 1'($urandom));
      if (($urandom % 8) == 0) idle_hold();
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule